// File: doc/BRIEF.md
# Microcode Datapath Arithmetic Unit with Borrow-Inverted Carry

This block is the arithmetic stage of a microcoded processor datapath. Each cycle it combines a 16-bit bus operand with the T register operand under a 4-bit function select. It returns a 16-bit result and a carry bit combinationally. A carry flag register captures that carry at the clock edge when the microinstruction enables it.

Addition functions report the unsigned carry out of bit 16. Subtract-style functions follow a borrow-inverted rule: carry is 1 only when the exact integer result is strictly positive. A zero or negative difference gives carry 0. A force-zero input replaces the bus operand with 0, so "0 plus T" runs in the same cycle that the register file is being loaded.

There is no sequencing state. The only stored bit is the carry flag. Its register has two behaviours: it is in reset, or it is running. While running it either loads the new carry or holds the old one, as the enable input selects.

Top module: `alu16_core`

## Requirements
- R1: While `rst_n` is low, `carry_q` is 0.
- R2: The logic codes give carry 0: pass (0) returns the bus, AND (7), OR (8) and XOR (9) combine bus and T bit by bit.
- R3: Increment (1), add (3) and add-plus-one (6) compute bus+1, bus+T and bus+T+1. The result is the low 16 bits and carry is bit 16 of the unsigned 17-bit sum.
- R4: For decrement (2), carry is 1 exactly when bus−1 is greater than 0 as an integer, that is when bus > 1.
- R5: For subtract (4), carry is 1 exactly when bus−T is greater than 0, so equal operands give carry 0.
- R6: For subtract-minus-one (5), carry is 1 exactly when bus−T−1 is greater than 0 as an integer.
- R7: Every subtract-style result is the low 16 bits of the two's-complement difference.
- R8: When `zero_bus` is 1, every function uses 0 in place of `bus_in`.
- R9: At a rising edge with `carry_en` high, `carry_q` takes `carry_out`. With `carry_en` low it keeps its value.
- R10: Codes 10 to 15 give result 0 and carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the carry flag |
| bus_in | input | 16 | Bus operand |
| t_in | input | 16 | T register operand |
| func | input | 4 | Function select (codes 0 to 9, others unused) |
| zero_bus | input | 1 | Forces the bus operand to 0 |
| carry_en | input | 1 | Enables loading of the carry flag |
| result | output | 16 | Combinational result |
| carry_out | output | 1 | Combinational carry of the current function |
| carry_q | output | 1 | Registered carry flag |

## Verification
The clocked checks assume that `func`, `bus_in`, `t_in` and `zero_bus` are settled before each rising edge and carry no X values. They also assume `carry_en` is held low during reset. The bench therefore changes every input on the falling edge only, and it drives known values from time zero. The stimulus includes the boundary operands where the borrow rule flips: equal operands, a result of exactly one, and wrap through zero.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
    localparam int DATA_W = 16;
    localparam int FN_W   = 4;

    typedef enum logic [FN_W-1:0] {
        FN_PASS  = 4'd0,
        FN_INC   = 4'd1,
        FN_DEC   = 4'd2,
        FN_ADD   = 4'd3,
        FN_SUB   = 4'd4,
        FN_SUBM1 = 4'd5,
        FN_ADDP1 = 4'd6,
        FN_AND   = 4'd7,
        FN_OR    = 4'd8,
        FN_XOR   = 4'd9
    } alu_fn_e;

    typedef enum logic [1:0] {
        LG_PASS = 2'd0,
        LG_AND  = 2'd1,
        LG_OR   = 2'd2,
        LG_XOR  = 2'd3
    } logic_op_e;
endpackage

// File: rtl/alu16_arith.sv
module alu16_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         do_sub,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int XW = W + 2;

    logic [XW-1:0] ext_a;
    logic [XW-1:0] ext_b;
    logic [XW-1:0] ext_c;
    logic [XW-1:0] sum_x;
    logic [XW-1:0] dif_x;

    assign ext_a = {2'b00, opa};
    assign ext_b = {2'b00, opb};
    assign ext_c = {{(XW-1){1'b0}}, cin};
    assign sum_x = ext_a + ext_b + ext_c;
    assign dif_x = ext_a - ext_b - ext_c;

    always_comb begin
        if (do_sub) begin
            res  = dif_x[W-1:0];
            // positive exact difference only: sign clear and not zero
            cout = !dif_x[XW-1] && (dif_x != '0);
        end else begin
            res  = sum_x[W-1:0];
            cout = sum_x[W];
        end
    end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic #(
    parameter int W = 16
) (
    input  logic [W-1:0]         opa,
    input  logic [W-1:0]         opb,
    input  alu16_pkg::logic_op_e op,
    output logic [W-1:0]         res
);
    import alu16_pkg::*;

    always_comb begin
        unique case (op)
            LG_PASS: res = opa;
            LG_AND:  res = opa & opb;
            LG_OR:   res = opa | opb;
            LG_XOR:  res = opa ^ opb;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu16_carry_reg.sv
module alu16_carry_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic d,
    output logic q
);
    typedef enum logic {CF_RESET, CF_RUN} cf_state_e;

    cf_state_e state;
    logic      flag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CF_RESET;
            flag  <= 1'b0;
        end else begin
            state <= CF_RUN;
            if (load) flag <= d;
        end
    end

    always_comb begin
        unique case (state)
            CF_RESET: q = 1'b0;
            CF_RUN:   q = flag;
            default:  q = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu16_core.sv
module alu16_core #(
    parameter int W = alu16_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bus_in,
    input  logic [W-1:0] t_in,
    input  logic [3:0]   func,
    input  logic         zero_bus,
    input  logic         carry_en,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         carry_q
);
    import alu16_pkg::*;

    logic [W-1:0] bus_eff;
    logic [W-1:0] ar_b;
    logic         ar_sub;
    logic         ar_cin;
    logic [W-1:0] ar_res;
    logic         ar_cout;
    logic [W-1:0] lg_res;
    logic_op_e    lg_op;
    logic         sel_arith;
    logic         sel_logic;

    assign bus_eff = zero_bus ? '0 : bus_in;

    always_comb begin
        ar_b      = t_in;
        ar_sub    = 1'b0;
        ar_cin    = 1'b0;
        lg_op     = LG_PASS;
        sel_arith = 1'b0;
        sel_logic = 1'b0;
        case (func)
            FN_PASS:  begin sel_logic = 1'b1; lg_op = LG_PASS; end
            FN_AND:   begin sel_logic = 1'b1; lg_op = LG_AND;  end
            FN_OR:    begin sel_logic = 1'b1; lg_op = LG_OR;   end
            FN_XOR:   begin sel_logic = 1'b1; lg_op = LG_XOR;  end
            FN_INC:   begin sel_arith = 1'b1; ar_b = W'(1); end
            FN_DEC:   begin sel_arith = 1'b1; ar_b = W'(1); ar_sub = 1'b1; end
            FN_ADD:   begin sel_arith = 1'b1; end
            FN_SUB:   begin sel_arith = 1'b1; ar_sub = 1'b1; end
            FN_SUBM1: begin sel_arith = 1'b1; ar_sub = 1'b1; ar_cin = 1'b1; end
            FN_ADDP1: begin sel_arith = 1'b1; ar_cin = 1'b1; end
            default:  ;
        endcase
    end

    alu16_arith #(.W(W)) u_arith (
        .opa    (bus_eff),
        .opb    (ar_b),
        .do_sub (ar_sub),
        .cin    (ar_cin),
        .res    (ar_res),
        .cout   (ar_cout)
    );

    alu16_logic #(.W(W)) u_logic (
        .opa (bus_eff),
        .opb (t_in),
        .op  (lg_op),
        .res (lg_res)
    );

    always_comb begin
        if (sel_arith) begin
            result    = ar_res;
            carry_out = ar_cout;
        end else if (sel_logic) begin
            result    = lg_res;
            carry_out = 1'b0;
        end else begin
            result    = '0;
            carry_out = 1'b0;
        end
    end

    alu16_carry_reg u_cflag (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (carry_en),
        .d     (carry_out),
        .q     (carry_q)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(!rst_n) |-> !carry_q);  // R1
    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (func == FN_AND || func == FN_OR || func == FN_XOR || func == FN_PASS) |-> !carry_out);  // R2
    AST_DEC_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        (func == FN_DEC && bus_eff <= W'(1)) |-> !carry_out);  // R4
    AST_SUB_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (func == FN_SUB && bus_eff == t_in) |-> (!carry_out && result == '0));  // R5
    AST_ZERO_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_bus && func == FN_PASS) |-> (result == '0));  // R8
    AST_CARRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        carry_en |=> (carry_q == $past(carry_out)));  // R9
    AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_en |=> $stable(carry_q));  // R9
    AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (func > 4'd9) |-> (result == '0 && !carry_out));  // R10
endmodule

// File: tb/alu16_core_tb.sv
module alu16_core_tb;
    typedef struct packed {
        logic [3:0]  fn;
        logic [15:0] a;
        logic [15:0] b;
        logic        zb;
        logic [15:0] res;
        logic        c;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 16'h1234, 16'h0000, 1'b0, 16'h1234, 1'b0, 8'd2},  // R2 pass
        '{4'd7, 16'hA5A5, 16'h0FF0, 1'b0, 16'h05A0, 1'b0, 8'd2},  // R2 and
        '{4'd8, 16'hA5A5, 16'h0FF0, 1'b0, 16'hAFF5, 1'b0, 8'd2},  // R2 or
        '{4'd9, 16'hA5A5, 16'h0FF0, 1'b0, 16'hAA55, 1'b0, 8'd2},  // R2 xor
        '{4'd1, 16'hFFFF, 16'h0000, 1'b0, 16'h0000, 1'b1, 8'd3},  // R3 inc wrap
        '{4'd1, 16'h0010, 16'h0000, 1'b0, 16'h0011, 1'b0, 8'd3},  // R3
        '{4'd3, 16'h8000, 16'h8001, 1'b0, 16'h0001, 1'b1, 8'd3},  // R3
        '{4'd3, 16'h1234, 16'h0001, 1'b0, 16'h1235, 1'b0, 8'd3},  // R3
        '{4'd6, 16'hFFFF, 16'h0000, 1'b0, 16'h0000, 1'b1, 8'd3},  // R3 plus one wrap
        '{4'd6, 16'h0001, 16'h0002, 1'b0, 16'h0004, 1'b0, 8'd3},  // R3
        '{4'd2, 16'h0001, 16'h0000, 1'b0, 16'h0000, 1'b0, 8'd4},  // R4 zero result
        '{4'd2, 16'h0000, 16'h0000, 1'b0, 16'hFFFF, 1'b0, 8'd7},  // R7 R4 negative
        '{4'd2, 16'h0002, 16'h0000, 1'b0, 16'h0001, 1'b1, 8'd4},  // R4 positive
        '{4'd4, 16'h0005, 16'h0005, 1'b0, 16'h0000, 1'b0, 8'd5},  // R5 equal
        '{4'd4, 16'h0003, 16'h0005, 1'b0, 16'hFFFE, 1'b0, 8'd7},  // R7 R5 negative
        '{4'd4, 16'h0009, 16'h0004, 1'b0, 16'h0005, 1'b1, 8'd5},  // R5
        '{4'd5, 16'h0006, 16'h0005, 1'b0, 16'h0000, 1'b0, 8'd6},  // R6 zero
        '{4'd5, 16'h0007, 16'h0005, 1'b0, 16'h0001, 1'b1, 8'd6},  // R6 one
        '{4'd5, 16'h0000, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 8'd7},  // R7 R6 low bits zero, negative
        '{4'd5, 16'hFFFF, 16'h0000, 1'b0, 16'hFFFE, 1'b1, 8'd6},  // R6
        '{4'd3, 16'h7777, 16'h0042, 1'b1, 16'h0042, 1'b0, 8'd8},  // R8 zero plus T
        '{4'd4, 16'hFFFF, 16'h0001, 1'b1, 16'hFFFF, 1'b0, 8'd8},  // R8
        '{4'd12, 16'h1234, 16'h5678, 1'b0, 16'h0000, 1'b0, 8'd10} // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_in = '0;
    logic [15:0] t_in = '0;
    logic [3:0]  func = '0;
    logic        zero_bus = 1'b0;
    logic        carry_en = 1'b0;
    logic [15:0] result;
    logic        carry_out;
    logic        carry_q;
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    alu16_core u_dut (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .t_in(t_in), .func(func),
        .zero_bus(zero_bus), .carry_en(carry_en),
        .result(result), .carry_out(carry_out), .carry_q(carry_q)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 carry_q in reset", {15'd0, carry_q}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            func = VECS[i].fn; bus_in = VECS[i].a; t_in = VECS[i].b; zero_bus = VECS[i].zb;
            #1;
            chk($sformatf("R%0d vec %0d result", VECS[i].req, i), result, VECS[i].res);
            chk($sformatf("R%0d vec %0d carry", VECS[i].req, i), {15'd0, carry_out}, {15'd0, VECS[i].c});
            @(negedge clk);
        end
        zero_bus = 1'b0;

        // R9 load a 1
        func = 4'd1; bus_in = 16'hFFFF; carry_en = 1'b1;
        @(negedge clk);
        chk("R9 load one", {15'd0, carry_q}, 16'h0001);
        // R9 hold with enable low while carry_out is 0
        func = 4'd0; carry_en = 1'b0;
        @(negedge clk);
        chk("R9 hold", {15'd0, carry_q}, 16'h0001);
        // R9 load a 0
        carry_en = 1'b1;
        @(negedge clk);
        chk("R9 load zero", {15'd0, carry_q}, 16'h0000);
        // reload 1, then reset clears it
        func = 4'd4; bus_in = 16'h0009; t_in = 16'h0004;
        @(negedge clk);
        chk("R9 load sub carry", {15'd0, carry_q}, 16'h0001);
        carry_en = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears flag", {15'd0, carry_q}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule